// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a successive-approximation converter. A falling edge on the active-low start input launches a conversion. Once launched, the conversion runs for a fixed number of clock cycles, set by a parameter, and `busy` is high for that whole time. Nothing can cut it short. The value to be converted arrives on `sample_in`: it is captured on the cycle the conversion begins and becomes the visible result on the cycle `busy` falls.

In the fast timing mode, the sequencer can retrigger itself. If start is still low when a conversion finishes, the sequencer runs its own acquisition window and then begins the next conversion, and it keeps doing so for as long as start stays low. A power-down request is honoured only outside a conversion. While powered down, the sequencer ignores start edges.

The result goes out on a tri-state parallel bus. That bus is gated by the OR of the active-low chip-select and read strobes, and by a serial/parallel select. A coding select picks between two's complement and offset (straight) binary at run time. The bus has no handshake and no back-pressure: a reader simply sees the current result word whenever the bus is enabled.

Top module: `sar_conv_ctl`

## Requirements
- R1: When the sequencer is idle, a clock edge that samples `start_n` low, where the previous sample was high, starts a conversion. `busy` is high from the next cycle for exactly CONV_CYCLES cycles. The value of `sample_in` at that edge is the value converted.
- R2: Once started, a conversion always lasts CONV_CYCLES cycles. Further start edges and `pwr_dn` neither shorten it nor restart it.
- R3: The levels of `cs_n`, `rd_n` and `ser_sel` have no effect on when conversions start or end.
- R4: With `fast_mode`=1, if `start_n` is low on the cycle a conversion ends, `busy` stays low for ACQ_CYCLES cycles and then a new conversion begins. This repeats while `start_n` stays low. If `start_n` goes high during the acquisition window, the sequencer returns to idle.
- R5: After reset, holding `start_n` low starts nothing. A conversion requires `start_n` to be seen high and then low.
- R6: `data_oe` is 1, and `data_bus` drives the result, only when `cs_n`=0, `rd_n`=0 and `ser_sel`=0. Otherwise `data_oe` is 0 and `data_bus` is high-impedance.
- R7: The result register resets to zero and changes only on the cycle `busy` falls. A read during a conversion returns the previous result.
- R8: When `twos_sel`=1, the bus carries the result unchanged as two's complement. When `twos_sel`=0, bit W-1 is inverted to give straight binary. The change takes effect without waiting for a clock.
- R9: With `fast_mode`=0, holding `start_n` low produces a single conversion and no self-retrigger.
- R10: If `pwr_dn` is seen at any time during a conversion, the sequencer enters power-down after `busy` falls. If `pwr_dn` is seen while idle or acquiring, it enters power-down on the next cycle. It stays powered down while `pwr_dn` is high. In power-down, start edges are ignored, and a new falling edge is needed after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_n | input | 1 | Conversion start, a falling edge triggers |
| pwr_dn | input | 1 | Power-down request |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| ser_sel | input | 1 | 1 selects serial readout, which keeps the parallel bus off |
| twos_sel | input | 1 | 1 selects two's complement, 0 selects straight binary |
| fast_mode | input | 1 | 1 enables self-retrigger while start is held low |
| sample_in | input | W | Value to be converted |
| busy | output | 1 | High during a conversion |
| data_oe | output | 1 | Parallel bus enable |
| data_bus | output | W | Tri-state result bus |

## Verification
Start is driven in four ways: as short pulses, as a low level held from reset, as repeated pulses inside a running conversion, and as a long held-low level in each timing mode. Together these separate edge triggering from level triggering, show that a conversion cannot be aborted, and distinguish self-retrigger from a single shot. The reading strobes are tried in every combination, and also while a conversion runs, so that the OR gating and the hold of the previous result are each shown. Power-down requests are placed in three spots: inside a conversion (released before it ends), while idle, and with start edges arriving during power-down. These show the latched deferral and that start edges are ignored while powered down.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_ACQ  = 2'd2,
    ST_PDN  = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic start_fall
);
  // Previous sample resets to "low" so a level held low through reset is not an edge.
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= start_n;
  end

  assign start_fall = prev_q & ~start_n;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctl_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int ACQ_CYCLES  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_fall,
  input  logic       start_lvl_n,
  input  logic       pwr_dn,
  input  logic       fast_mode,
  output logic       busy_o,
  output logic       samp_load,
  output logic       res_load,
  output sar_state_e state_o
);
  localparam int MAXC = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CONV_LD = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] ACQ_LD  = CW'(ACQ_CYCLES - 1);

  sar_state_e    state, nxt;
  logic [CW-1:0] cnt, nxt_cnt;
  logic          pend, nxt_pend;

  always_comb begin
    nxt       = state;
    nxt_cnt   = cnt;
    nxt_pend  = pend;
    samp_load = 1'b0;
    res_load  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pwr_dn) nxt = ST_PDN;
        else if (start_fall) begin
          nxt       = ST_CONV;
          nxt_cnt   = CONV_LD;
          samp_load = 1'b1;
        end
      end
      ST_CONV: begin
        if (pwr_dn) nxt_pend = 1'b1;
        if (cnt == '0) begin
          res_load = 1'b1;
          if (pend || pwr_dn) begin
            nxt      = ST_PDN;
            nxt_pend = 1'b0;
          end else if (fast_mode && !start_lvl_n) begin
            nxt     = ST_ACQ;
            nxt_cnt = ACQ_LD;
          end else begin
            nxt = ST_IDLE;
          end
        end else begin
          nxt_cnt = cnt - CW'(1);
        end
      end
      ST_ACQ: begin
        if (pwr_dn) nxt = ST_PDN;
        else if (start_lvl_n) nxt = ST_IDLE;
        else if (cnt == '0) begin
          nxt       = ST_CONV;
          nxt_cnt   = CONV_LD;
          samp_load = 1'b1;
        end else begin
          nxt_cnt = cnt - CW'(1);
        end
      end
      ST_PDN: begin
        if (!pwr_dn) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      pend   <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      state  <= nxt;
      cnt    <= nxt_cnt;
      pend   <= nxt_pend;
      busy_o <= (nxt == ST_CONV);
    end
  end

  assign state_o = state;

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && cnt != '0) |=> busy_o); // R2
  AST_BUSY_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_fall) || $past(state) == ST_ACQ)); // R1
  AST_NO_SELF_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_mode && state == ST_CONV) |=> state != ST_ACQ); // R9
  AST_PDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDN && pwr_dn) |=> (state == ST_PDN && !busy_o)); // R10
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         samp_load,
  input  logic         res_load,
  input  logic         twos_sel,
  input  logic [W-1:0] sample_in,
  output logic [W-1:0] word_o
);
  logic [W-1:0] samp_q, res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= '0;
      res_q  <= '0;
    end else begin
      if (samp_load) samp_q <= sample_in;
      if (res_load)  res_q  <= samp_q;
    end
  end

  assign word_o = twos_sel ? res_q : {~res_q[W-1], res_q[W-2:0]};

  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_load |=> $stable(res_q)); // R7
endmodule

// File: rtl/sar_bus.sv
module sar_bus #(
  parameter int W = 16
) (
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         ser_sel,
  input  logic [W-1:0] word,
  output logic         oe,
  output logic [W-1:0] data_bus
);
  assign oe       = ~(cs_n | rd_n) & ~ser_sel;
  assign data_bus = oe ? word : 'z;
endmodule

// File: rtl/sar_conv_ctl.sv
module sar_conv_ctl
  import sar_ctl_pkg::*;
#(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 20,
  parameter int ACQ_CYCLES  = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_n,
  input  logic         pwr_dn,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         ser_sel,
  input  logic         twos_sel,
  input  logic         fast_mode,
  input  logic [W-1:0] sample_in,
  output logic         busy,
  output logic         data_oe,
  output logic [W-1:0] data_bus
);
  logic         start_fall, samp_load, res_load;
  logic [W-1:0] word;
  sar_state_e   state;

  sar_start_edge u_edge (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .start_fall(start_fall)
  );

  sar_seq #(.CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_fall(start_fall), .start_lvl_n(start_n),
    .pwr_dn(pwr_dn), .fast_mode(fast_mode), .busy_o(busy),
    .samp_load(samp_load), .res_load(res_load), .state_o(state)
  );

  sar_result #(.W(W)) u_res (
    .clk(clk), .rst_n(rst_n), .samp_load(samp_load), .res_load(res_load),
    .twos_sel(twos_sel), .sample_in(sample_in), .word_o(word)
  );

  sar_bus #(.W(W)) u_bus (
    .cs_n(cs_n), .rd_n(rd_n), .ser_sel(ser_sel), .word(word),
    .oe(data_oe), .data_bus(data_bus)
  );

  AST_PDN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDN && start_fall) |=> !busy); // R10
endmodule

// File: tb/tb_sar_conv_ctl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctl;
  localparam int W = 16, CONV = 20, ACQ = 6;

  logic clk = 1'b0;
  logic rst_n, start_n, pwr_dn, cs_n, rd_n, ser_sel, twos_sel, fast_mode;
  logic [W-1:0] sample_in;
  logic busy, data_oe;
  wire  [W-1:0] data_bus;

  sar_conv_ctl #(.W(W), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pwr_dn(pwr_dn),
    .cs_n(cs_n), .rd_n(rd_n), .ser_sel(ser_sel), .twos_sel(twos_sel),
    .fast_mode(fast_mode), .sample_in(sample_in), .busy(busy),
    .data_oe(data_oe), .data_bus(data_bus)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, rises = 0;
  string cur = "R5";
  bit done = 0;

  // behavioural reference: 0 idle, 1 converting, 2 acquiring, 3 powered down
  int m_st = 0, m_cnt = 0;
  bit m_prev = 0, m_pend = 0;
  logic [W-1:0] m_samp = '0, m_res = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_prev = 0; m_pend = 0; m_samp = '0; m_res = '0;
    end else begin
      bit fall;
      fall = m_prev && !start_n;
      case (m_st)
        0: if (pwr_dn) m_st = 3;
           else if (fall) begin m_st = 1; m_cnt = CONV; m_samp = sample_in; end
        1: begin
          if (pwr_dn) m_pend = 1;
          m_cnt--;
          if (m_cnt == 0) begin
            m_res = m_samp;
            if (m_pend) m_st = 3;
            else if (fast_mode && !start_n) begin m_st = 2; m_cnt = ACQ; end
            else m_st = 0;
          end
        end
        2: if (pwr_dn) m_st = 3;
           else if (start_n) m_st = 0;
           else begin
             m_cnt--;
             if (m_cnt == 0) begin m_st = 1; m_cnt = CONV; m_samp = sample_in; end
           end
        default: begin m_pend = 0; if (!pwr_dn) m_st = 0; end
      endcase
      m_prev = start_n;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  bit prev_busy = 0;
  always @(posedge clk) begin
    #3;
    if (!done) begin
      logic [W-1:0] e;
      e = twos_sel ? m_res : {~m_res[W-1], m_res[W-2:0]};
      check({cur, " busy"}, W'(busy), W'(m_st == 1));
      check({cur, " oe"}, W'(data_oe), W'(!cs_n && !rd_n && !ser_sel));
      if (!cs_n && !rd_n && !ser_sel) check({cur, " data"}, data_bus, e);
      if (busy && !prev_busy) rises++;
      prev_busy = busy;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; start_n = 0; pwr_dn = 0; cs_n = 1; rd_n = 1; ser_sel = 0;
    twos_sel = 1; fast_mode = 0; sample_in = '0;
    cyc(3);
    check("R7 reset busy", W'(busy), '0);
    rst_n = 1;
    // R5: start held low from reset does nothing
    cur = "R5"; cyc(10);
    check("R5 no start", W'(busy), '0);
    // R1: edge starts conversion; sample captured at edge
    cur = "R1"; start_n = 1; cyc(2);
    sample_in = 16'h1234; start_n = 0; cyc(1);
    sample_in = 16'h5555; start_n = 1; cyc(1);
    check("R1 busy up", W'(busy), W'(1));
    cyc(CONV - 2);
    check("R1 busy end", W'(busy), W'(1));
    cyc(1);
    check("R1 busy low", W'(busy), '0);
    cyc(3);
    // R7/R8 read
    cur = "R8"; cs_n = 0; rd_n = 0; cyc(1);
    check("R7 result", data_bus, 16'h1234);
    twos_sel = 0; #1;
    check("R8 straight", data_bus, 16'h9234);
    twos_sel = 1;
    // R3/R2/R7: conversion while bus read, extra edges inside
    cur = "R2"; sample_in = 16'h0F0F; start_n = 0; cyc(1); start_n = 1; cyc(5);
    check("R7 old during conv", data_bus, 16'h1234);
    check("R3 started while reading", W'(busy), W'(1));
    start_n = 0; cyc(2); start_n = 1; cyc(3); start_n = 0; cyc(1); start_n = 1;
    cyc(15);
    check("R2 new result", data_bus, 16'h0F0F);
    // R6 gating
    cur = "R6"; cs_n = 1; rd_n = 0; #1; check("R6 cs", W'(data_oe), '0);
    cs_n = 0; rd_n = 1; #1; check("R6 rd", W'(data_oe), '0);
    rd_n = 0; ser_sel = 1; #1; check("R6 ser", W'(data_oe), '0);
    ser_sel = 0; #1; check("R6 on", W'(data_oe), W'(1));
    cyc(2);
    // R10: power-down during conversion latched
    cur = "R10"; sample_in = 16'hAAAA; start_n = 0; cyc(1); start_n = 1; cyc(3);
    pwr_dn = 1; cyc(2); pwr_dn = 0; cyc(1);
    check("R2 pd no abort", W'(busy), W'(1));
    cyc(20);
    pwr_dn = 1; cyc(3);
    start_n = 0; cyc(2); start_n = 1; cyc(2); start_n = 0; cyc(1); start_n = 1; cyc(2);
    check("R10 ignored in pdn", W'(busy), '0);
    pwr_dn = 0; cyc(4);
    check("R10 no start after release", W'(busy), '0);
    check("R10 result", data_bus, 16'hAAAA);
    // R4: self retrigger in fast mode
    cur = "R4"; fast_mode = 1; sample_in = 16'h0001; cyc(1);
    rises = 0; start_n = 0; cyc(24); sample_in = 16'h0002; cyc(46);
    check("R4 retrigger count", W'(rises), W'(3));
    start_n = 1; cyc(30);
    start_n = 0; cyc(25); start_n = 1; cyc(10);
    check("R4 back to idle", W'(busy), '0);
    // R9: single shot in normal mode
    cur = "R9"; fast_mode = 0; cyc(1);
    rises = 0; start_n = 0; cyc(70);
    check("R9 single shot", W'(rises), W'(1));
    start_n = 1; cyc(5);
    finish_run();
  end
endmodule